// File: doc/BRIEF.md
# Workgroup Dispatcher for Kernel Launches

The block sits between a host and an array of compute units. The host writes a launch descriptor into a small register window. The descriptor holds a grid size and a workgroup size for each of three dimensions. The host then writes offset 0 to launch the kernel. On launch the block divides the grid into workgroups and takes a free slot in a four-entry kernel table. It gives the kernel the next sequential kernel ID and appends the slot to an execution queue.

Workgroups leave the block one per cycle over a valid/ready handshake. Each one carries its slot, its kernel ID, its three-dimensional index and its linear index. The compute array hands back a completion tagged with the slot. When a kernel's last workgroup completes, the block reports it once on a done strobe. At the end of the next scheduling pass it raises a host wake pulse.

Scheduling runs in passes. In each pass the kernel at the head of the queue streams its workgroups. If the array refuses one, that kernel moves to the back of the queue. A kernel behind it, perhaps with smaller workgroups, can then still dispatch in the same pass.

Top module: `wg_dispatcher`

## Requirements
- R1: 32-bit word writes at byte offsets 8, 12 and 16 set the grid size in dimensions 0, 1 and 2. Writes at 20, 24 and 28 set the workgroup size in dimensions 0, 1 and 2. Only the low 16 bits are kept, and each field reads back at its own offset. A read of any other offset except 0 returns zero.
- R2: A read of offset 0 returns the status word: bit 0 is the dispatch-active flag and bit 1 is the overflow flag. After an accepted launch write, bit 0 reads 1 in the following cycle.
- R3: In each dimension, the workgroup count is the grid size divided by the workgroup size, rounded up. A workgroup size of 0 counts as 1, and a count of 0 becomes 1. The kernel issues the product of the three counts as workgroups.
- R4: Kernel IDs are 0, 1, 2 and so on in order of accepted launch. A kernel's workgroups come out in row-major order, with dimension 0 changing fastest. The linear index starts at 0 and rises by 1 with each workgroup.
- R5: A workgroup transfers on each cycle where valid and ready are both high. Valid is high only during a scheduling pass.
- R6: If the array refuses the head kernel's workgroup, that kernel moves to the back of the queue and the fail count rises by one. A later kernel can then dispatch in the same pass. The pass ends once the queue length is no more than the fail count. The refused kernel next dispatches in a later pass.
- R7: A scheduling pass starts one cycle after an accepted launch or a completion. The first workgroup of a new kernel on an idle block is valid two cycles after the launch edge.
- R8: Completions are counted per slot. On the cycle after the completion that brings a kernel's count to its total, the done strobe pulses for one cycle with that kernel's ID.
- R9: If any kernel has finished since the last wake pulse, the wake pulse goes high for one cycle at the end of a pass. Without a finished kernel, there is no wake pulse.
- R10: At most 4 kernels are live at once. A launch write while 4 are live is ignored: no ID is used up and no workgroup is issued. The write also sets the overflow flag, which then stays set.
- R11: The dispatch-active flag clears once every launched kernel is done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_waddr_i | input | 12 | Write byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_raddr_i | input | 12 | Read byte offset |
| reg_rdata_o | output | 32 | Read data (combinational) |
| wg_valid_o | output | 1 | Workgroup offered |
| wg_ready_i | input | 1 | Compute array accepts the workgroup |
| wg_slot_o | output | 2 | Kernel table slot of the workgroup |
| wg_kid_o | output | 8 | Kernel ID |
| wg_x_o | output | 16 | Workgroup index, dimension 0 |
| wg_y_o | output | 16 | Workgroup index, dimension 1 |
| wg_z_o | output | 16 | Workgroup index, dimension 2 |
| wg_gid_o | output | 48 | Linear workgroup index |
| cmpl_valid_i | input | 1 | Workgroup completion strobe |
| cmpl_slot_i | input | 2 | Slot of the completed workgroup |
| done_valid_o | output | 1 | Kernel finished strobe |
| done_kid_o | output | 8 | ID of the finished kernel |
| wake_o | output | 1 | Host wake pulse |

## Verification
The bench refuses one chosen kernel while a second kernel sits behind it. A design without rotation would stall on the refused head and issue nothing. A design that rotated without counting failures would loop for ever or never end the pass. The bench fills all four slots and then launches again. A wrong full test would overwrite a live slot or use up a kernel ID, and the next accepted kernel would then carry the wrong ID. Zero workgroup and grid sizes check that the divide is guarded and each count is at least 1. An off-by-one in the ceiling would change the number of workgroups issued. The bench also checks the exact cycle of the first valid after a launch, and that wake stays low while kernels are only refused.

// File: rtl/wgd_pkg.sv
package wgd_pkg;
  parameter int NDIM  = 3;
  parameter int DIM_W = 16;
  parameter int KID_W = 8;
  parameter int TOT_W = NDIM * DIM_W;

  typedef logic [DIM_W-1:0] dim_t;
  typedef logic [TOT_W-1:0] tot_t;
  typedef logic [KID_W-1:0] kid_t;

  typedef struct packed {
    kid_t                 kid;
    dim_t [NDIM-1:0]      cnt;
    dim_t [NDIM-1:0]      idx;
    tot_t                 gid;
    tot_t                 tot;
    tot_t                 ncmp;
  } kent_t;
endpackage

// File: rtl/wgd_grid_setup.sv
module wgd_grid_setup
  import wgd_pkg::*;
(
  input  dim_t [NDIM-1:0] grid_i,
  input  dim_t [NDIM-1:0] wgs_i,
  output dim_t [NDIM-1:0] cnt_o,
  output tot_t            tot_o
);
  for (genvar d = 0; d < NDIM; d++) begin : g_dim
    dim_t             w_eff;
    logic [DIM_W:0]   num, quo;
    assign w_eff    = (wgs_i[d] == '0) ? dim_t'(1) : wgs_i[d];
    assign num      = {1'b0, grid_i[d]} + {1'b0, w_eff} - (DIM_W+1)'(1);
    assign quo      = num / {1'b0, w_eff};
    assign cnt_o[d] = (quo == '0) ? dim_t'(1) : quo[DIM_W-1:0];
  end

  always_comb begin
    tot_o = tot_t'(1);
    for (int d = 0; d < NDIM; d++) tot_o = tot_o * tot_t'(cnt_o[d]);
  end
endmodule

// File: rtl/wgd_kqueue.sv
module wgd_kqueue #(
  parameter int NK = 4,
  localparam int SW = (NK > 1) ? $clog2(NK) : 1,
  localparam int CW = $clog2(NK + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [SW-1:0] push_slot_i,
  input  logic          pop_i,
  input  logic          rot_i,
  output logic [SW-1:0] head_o,
  output logic [CW-1:0] cnt_o
);
  logic [SW-1:0] mem_q [NK];
  logic [SW-1:0] rd_q, wr_q;
  logic          do_wr, do_rd;
  logic [SW-1:0] wr_val;

  function automatic logic [SW-1:0] inc(input logic [SW-1:0] p);
    return (p == SW'(NK - 1)) ? '0 : p + SW'(1);
  endfunction

  assign do_wr  = push_i | rot_i;
  assign do_rd  = pop_i | rot_i;
  assign wr_val = rot_i ? mem_q[rd_q] : push_slot_i;
  assign head_o = mem_q[rd_q];

  always_ff @(posedge clk_i) if (do_wr) mem_q[wr_q] <= wr_val;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_o <= '0;
    end else begin
      if (do_wr) wr_q <= inc(wr_q);
      if (do_rd) rd_q <= inc(rd_q);
      cnt_o <= cnt_o + CW'(push_i) - CW'(pop_i);
    end
  end
endmodule

// File: rtl/wg_dispatcher.sv
module wg_dispatcher
  import wgd_pkg::*;
#(
  parameter int NK = 4,
  parameter int AW = 12,
  parameter int DW = 32,
  localparam int SW = (NK > 1) ? $clog2(NK) : 1,
  localparam int CW = $clog2(NK + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [AW-1:0]    reg_waddr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  input  logic [AW-1:0]    reg_raddr_i,
  output logic [DW-1:0]    reg_rdata_o,
  output logic             wg_valid_o,
  input  logic             wg_ready_i,
  output logic [SW-1:0]    wg_slot_o,
  output logic [KID_W-1:0] wg_kid_o,
  output logic [DIM_W-1:0] wg_x_o,
  output logic [DIM_W-1:0] wg_y_o,
  output logic [DIM_W-1:0] wg_z_o,
  output logic [TOT_W-1:0] wg_gid_o,
  input  logic             cmpl_valid_i,
  input  logic [SW-1:0]    cmpl_slot_i,
  output logic             done_valid_o,
  output logic [KID_W-1:0] done_kid_o,
  output logic             wake_o
);
  localparam int DESC_BASE = 8;
  localparam int NFIELD    = 2 * NDIM;
  localparam int FW        = $clog2(NFIELD);

  dim_t [NFIELD-1:0] desc_q;
  dim_t [NDIM-1:0]   grid_v, wgs_v, cnt_v;
  tot_t              tot_v;
  kent_t             tbl_q [NK];
  logic [NK-1:0]     live_q;
  kid_t              next_kid_q;
  logic              in_pass_q, trig_q, done_pend_q, ovf_q;
  logic [CW-1:0]     fail_q, q_cnt;
  logic [SW-1:0]     q_head, free_slot;

  // register window decode
  logic [AW-1:0] woff, roff;
  logic [AW-3:0] widx, ridx;
  logic          desc_we, rsel, launch_req, launch_ok, full;
  logic          unused_wdata;

  assign woff         = reg_waddr_i - AW'(DESC_BASE);
  assign widx         = woff[AW-1:2];
  assign desc_we      = reg_we_i && (reg_waddr_i >= AW'(DESC_BASE)) &&
                        (woff[1:0] == 2'b00) && (widx < (AW-2)'(NFIELD));
  assign roff         = reg_raddr_i - AW'(DESC_BASE);
  assign ridx         = roff[AW-1:2];
  assign rsel         = (reg_raddr_i >= AW'(DESC_BASE)) && (roff[1:0] == 2'b00) &&
                        (ridx < (AW-2)'(NFIELD));
  assign launch_req   = reg_we_i && (reg_waddr_i == '0);
  assign full         = &live_q;
  assign launch_ok    = launch_req && !full;
  assign unused_wdata = ^reg_wdata_i[DW-1:DIM_W];

  always_comb begin
    if (reg_raddr_i == '0) reg_rdata_o = DW'({ovf_q, |live_q});
    else if (rsel)         reg_rdata_o = DW'(desc_q[ridx[FW-1:0]]);
    else                   reg_rdata_o = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      desc_q <= '0;
    else if (desc_we) desc_q[widx[FW-1:0]] <= reg_wdata_i[DIM_W-1:0];
  end

  always_comb begin
    for (int d = 0; d < NDIM; d++) begin
      grid_v[d] = desc_q[d];
      wgs_v[d]  = desc_q[NDIM + d];
    end
  end

  wgd_grid_setup u_grid (.grid_i(grid_v), .wgs_i(wgs_v), .cnt_o(cnt_v), .tot_o(tot_v));

  always_comb begin
    free_slot = '0;
    for (int s = NK - 1; s >= 0; s--) if (!live_q[s]) free_slot = SW'(s);
  end

  // issue side
  kent_t           hd;
  dim_t [NDIM-1:0] nidx;
  logic            issue_en, fire, last, pop, rot, pass_end, start, carry;

  assign hd       = tbl_q[q_head];
  assign issue_en = in_pass_q && (q_cnt > fail_q);
  assign fire     = issue_en && wg_ready_i;
  assign last     = hd.gid == hd.tot - tot_t'(1);
  assign pop      = fire && last;
  assign rot      = issue_en && !wg_ready_i && !launch_ok;  // retry deferred on a push
  assign pass_end = in_pass_q && !issue_en;
  assign start    = !in_pass_q && trig_q;

  always_comb begin
    carry = 1'b1;
    nidx  = hd.idx;
    for (int d = 0; d < NDIM; d++) begin
      if (carry) begin
        if (hd.idx[d] == hd.cnt[d] - dim_t'(1)) nidx[d] = '0;
        else begin
          nidx[d] = hd.idx[d] + dim_t'(1);
          carry   = 1'b0;
        end
      end
    end
  end

  wgd_kqueue #(.NK(NK)) u_kq (
    .clk_i, .rst_ni,
    .push_i(launch_ok), .push_slot_i(free_slot),
    .pop_i(pop), .rot_i(rot),
    .head_o(q_head), .cnt_o(q_cnt)
  );

  assign wg_valid_o = issue_en;
  assign wg_slot_o  = q_head;
  assign wg_kid_o   = hd.kid;
  assign wg_x_o     = hd.idx[0];
  assign wg_y_o     = hd.idx[1];
  assign wg_z_o     = hd.idx[2];
  assign wg_gid_o   = hd.gid;

  // completion side
  logic cmpl_hit, done_evt;
  assign cmpl_hit = cmpl_valid_i && live_q[cmpl_slot_i];
  assign done_evt = cmpl_hit &&
                    (tbl_q[cmpl_slot_i].ncmp + tot_t'(1) == tbl_q[cmpl_slot_i].tot);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NK; s++) tbl_q[s] <= '0;
      live_q <= '0;
    end else begin
      for (int s = 0; s < NK; s++) begin
        if (launch_ok && free_slot == SW'(s)) begin
          tbl_q[s]     <= '0;
          tbl_q[s].kid <= next_kid_q;
          tbl_q[s].cnt <= cnt_v;
          tbl_q[s].tot <= tot_v;
          live_q[s]    <= 1'b1;
        end else begin
          if (fire && q_head == SW'(s)) begin
            tbl_q[s].idx <= nidx;
            tbl_q[s].gid <= tbl_q[s].gid + tot_t'(1);
          end
          if (cmpl_hit && cmpl_slot_i == SW'(s)) begin
            tbl_q[s].ncmp <= tbl_q[s].ncmp + tot_t'(1);
            if (done_evt) live_q[s] <= 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_kid_q   <= '0;
      in_pass_q    <= 1'b0;
      trig_q       <= 1'b0;
      fail_q       <= '0;
      done_pend_q  <= 1'b0;
      ovf_q        <= 1'b0;
      wake_o       <= 1'b0;
      done_valid_o <= 1'b0;
      done_kid_o   <= '0;
    end else begin
      if (launch_ok)  next_kid_q <= next_kid_q + kid_t'(1);
      if (launch_req && full) ovf_q <= 1'b1;
      trig_q <= (trig_q && !start) || launch_ok || cmpl_valid_i;
      if (start)         in_pass_q <= 1'b1;
      else if (pass_end) in_pass_q <= 1'b0;
      if (start)    fail_q <= '0;
      else if (rot) fail_q <= fail_q + CW'(1);
      wake_o <= pass_end && done_pend_q;
      if (pass_end)      done_pend_q <= done_evt;
      else if (done_evt) done_pend_q <= 1'b1;
      done_valid_o <= done_evt;
      if (done_evt) done_kid_o <= tbl_q[cmpl_slot_i].kid;
    end
  end
endmodule

// File: rtl/wgd_checker.sv
module wgd_checker #(
  parameter int NK = 4,
  parameter int AW = 12,
  localparam int CW = $clog2(NK + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reg_we_i,
  input logic [AW-1:0] reg_waddr_i,
  input logic          cmpl_valid_i,
  input logic          wg_valid_o,
  input logic          wake_o,
  input logic          done_valid_o,
  input logic          in_pass_q,
  input logic          ovf_q,
  input logic [NK-1:0] live_q,
  input logic [CW-1:0] q_cnt
);
  p_valid_in_pass_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wg_valid_o |-> in_pass_q);

  p_launch_active_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_waddr_i == '0 && !(&live_q)) |=> (|live_q));

  p_full_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_waddr_i == '0 && (&live_q) && !cmpl_valid_i) |=> (live_q == $past(live_q)));

  p_ovf_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q);

  p_queue_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_cnt <= CW'(NK));

  p_wake_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);

  p_done_after_cmpl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_valid_o) |-> $past(cmpl_valid_i));
endmodule

bind wg_dispatcher wgd_checker #(.NK(NK), .AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_waddr_i(reg_waddr_i),
  .cmpl_valid_i(cmpl_valid_i), .wg_valid_o(wg_valid_o), .wake_o(wake_o),
  .done_valid_o(done_valid_o), .in_pass_q(in_pass_q), .ovf_q(ovf_q),
  .live_q(live_q), .q_cnt(q_cnt)
);

// File: tb/wg_dispatcher_tb.sv
module wg_dispatcher_tb;
  import wgd_pkg::*;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0]  kid;
    logic [15:0] x, y, z;
    logic [47:0] gid;
  } item_t;

  logic        clk = 0, rst_n = 0;
  logic        we = 0;
  logic [11:0] waddr = 0, raddr = 0;
  logic [31:0] wdata = 0, rdata;
  logic        wg_valid, wg_ready;
  logic [1:0]  wg_slot;
  logic [7:0]  wg_kid, done_kid;
  logic [15:0] wg_x, wg_y, wg_z;
  logic [47:0] wg_gid;
  logic        cmpl_valid = 0;
  logic [1:0]  cmpl_slot = 0;
  logic        done_valid, wake;
  logic        refuse_all = 0, refuse_en = 0;
  logic [7:0]  refuse_kid = 0;

  int errs = 0, checks = 0, wake_cnt = 0, issued = 0, next_kid = 0;
  item_t      exp_q[$];
  logic [1:0] cmp_q[$];
  logic [7:0] done_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign wg_ready = !refuse_all && !(refuse_en && wg_kid == refuse_kid);

  wg_dispatcher u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_waddr_i(waddr), .reg_wdata_i(wdata),
    .reg_raddr_i(raddr), .reg_rdata_o(rdata), .wg_valid_o(wg_valid), .wg_ready_i(wg_ready),
    .wg_slot_o(wg_slot), .wg_kid_o(wg_kid), .wg_x_o(wg_x), .wg_y_o(wg_y), .wg_z_o(wg_z),
    .wg_gid_o(wg_gid), .cmpl_valid_i(cmpl_valid), .cmpl_slot_i(cmpl_slot),
    .done_valid_o(done_valid), .done_kid_o(done_kid), .wake_o(wake)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && wg_valid && wg_ready) begin
      item_t got;
      got = {wg_kid, wg_x, wg_y, wg_z, wg_gid};
      issued++;
      cmp_q.push_back(wg_slot);
      checks++;
      if (exp_q.size() == 0) begin
        errs++;
        $display("FAIL R4 unexpected workgroup: got kid=%0d gid=%0d expected none", wg_kid, wg_gid);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        if (got !== e) begin
          errs++;
          $display("FAIL R4 workgroup: got kid=%0d x=%0d y=%0d z=%0d gid=%0d expected kid=%0d x=%0d y=%0d z=%0d gid=%0d",
                   got.kid, got.x, got.y, got.z, got.gid, e.kid, e.x, e.y, e.z, e.gid);
        end
      end
    end
    if (rst_n && done_valid) done_q.push_back(done_kid);
    if (rst_n && wake) wake_cnt++;
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input int addr, input int data);
    @(posedge clk); #1;
    we = 1; waddr = 12'(addr); wdata = data;
    @(posedge clk); #1;
    we = 0;
  endtask

  task automatic rd(input int addr, output logic [31:0] v);
    raddr = 12'(addr); #1; v = rdata;
  endtask

  // expected workgroups of one kernel, row-major, dimension 0 fastest (R3, R4)
  task automatic exp_kernel(input int kid, input int g0, g1, g2, w0, w1, w2);
    int g[3], w[3], n[3];
    longint gid = 0;
    g = '{g0, g1, g2}; w = '{w0, w1, w2};
    for (int d = 0; d < 3; d++) begin
      int we_ = (w[d] == 0) ? 1 : w[d];
      n[d] = (g[d] + we_ - 1) / we_;
      if (n[d] == 0) n[d] = 1;
    end
    for (int z = 0; z < n[2]; z++)
      for (int y = 0; y < n[1]; y++)
        for (int x = 0; x < n[0]; x++) begin
          exp_q.push_back({8'(kid), 16'(x), 16'(y), 16'(z), 48'(gid)});
          gid++;
        end
  endtask

  task automatic set_desc(input int g0, g1, g2, w0, w1, w2);
    wr(8, g0); wr(12, g1); wr(16, g2); wr(20, w0); wr(24, w1); wr(28, w2);
  endtask

  task automatic launch(input int g0, g1, g2, w0, w1, w2);
    set_desc(g0, g1, g2, w0, w1, w2);
    wr(0, 1);
    cyc(6);
  endtask

  task automatic complete_all();
    while (cmp_q.size() > 0) begin
      @(posedge clk); #1;
      cmpl_valid = 1; cmpl_slot = cmp_q.pop_front();
    end
    @(posedge clk); #1;
    cmpl_valid = 0;
    cyc(8);
  endtask

  task automatic chk_done(input int kid, input string req);
    if (done_q.size() == 0) chk(0, req, "done strobe missing", -1, kid);
    else begin
      logic [7:0] k;
      k = done_q.pop_front();
      chk(k == 8'(kid), req, "done kernel id", k, kid);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errs++;
    $display("FAIL R5 watchdog expired: got 1 expected 0");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int w0, i0;
    cyc(3);
    @(negedge clk); rst_n = 1;
    cyc(2);

    // reset state
    rd(0, v);   chk(v == 0, "R2", "status after reset", v, 0);
    chk(!wg_valid, "R5", "valid after reset", wg_valid, 0);
    chk(!done_valid && !wake, "R9", "done/wake after reset", {done_valid, wake}, 0);

    // R1 register window
    wr(8, 5); wr(12, 32'h12345); wr(28, 7);
    rd(8, v);  chk(v == 5, "R1", "grid x readback", v, 5);
    rd(12, v); chk(v == 32'h2345, "R1", "grid y low 16 bits", v, 32'h2345);
    rd(28, v); chk(v == 7, "R1", "wg z readback", v, 7);
    rd(4, v);  chk(v == 0, "R1", "offset 4 reads zero", v, 0);
    rd(40, v); chk(v == 0, "R1", "offset 40 reads zero", v, 0);

    // kernel 0: grid 5x3x1, wg 2x2x1 -> 3x2x1, with launch timing (R7)
    exp_kernel(next_kid, 5, 3, 1, 2, 2, 1); next_kid++;
    set_desc(5, 3, 1, 2, 2, 1);
    @(posedge clk); #1; we = 1; waddr = 0; wdata = 1;
    @(posedge clk); #1; we = 0;
    rd(0, v); chk(v[0] == 1, "R2", "active one cycle after launch", v[0], 1);
    chk(!wg_valid, "R7", "no valid in launch+1 cycle", wg_valid, 0);
    @(posedge clk); #1;
    chk(wg_valid, "R7", "valid in launch+2 cycle", wg_valid, 1);
    cyc(15);
    chk(issued == 6, "R3", "workgroup count 3x2x1", issued, 6);
    chk(exp_q.size() == 0, "R4", "all expected issued", exp_q.size(), 0);
    chk(wake_cnt == 0, "R9", "no wake before completion", wake_cnt, 0);
    complete_all();
    chk_done(0, "R8");
    chk(wake_cnt == 1, "R9", "wake after kernel done", wake_cnt, 1);
    rd(0, v); chk(v == 0, "R11", "active cleared", v, 0);

    // kernel 1: zero sizes guarded -> 3x1x2 (R3)
    exp_kernel(next_kid, 3, 0, 4, 0, 5, 2); next_kid++;
    i0 = issued;
    launch(3, 0, 4, 0, 5, 2);
    cyc(10);
    chk(issued - i0 == 6, "R3", "zero-size workgroup count", issued - i0, 6);
    complete_all();
    chk_done(1, "R8");

    // R6 rotation: kernel 2 refused, kernel 3 dispatches in the same pass
    refuse_en = 1; refuse_kid = 8'(next_kid);
    exp_kernel(next_kid + 1, 2, 1, 1, 1, 1, 1);
    exp_kernel(next_kid, 2, 1, 1, 1, 1, 1);
    i0 = issued;
    launch(2, 1, 1, 1, 1, 1);
    chk(issued == i0, "R6", "refused kernel issues nothing", issued - i0, 0);
    launch(2, 1, 1, 1, 1, 1);
    cyc(6);
    chk(issued - i0 == 2, "R6", "later kernel dispatched past refused head", issued - i0, 2);
    refuse_en = 0;
    cyc(6);
    chk(exp_q.size() == 2, "R6", "refused kernel waits for next pass", exp_q.size(), 2);
    complete_all();
    chk(exp_q.size() == 0, "R6", "refused kernel resumes", exp_q.size(), 0);
    complete_all();
    chk_done(next_kid + 1, "R8");
    chk_done(next_kid, "R8");
    next_kid += 2;

    // R10 capacity and overflow
    w0 = wake_cnt;
    refuse_all = 1;
    for (int k = 0; k < 4; k++) exp_kernel(next_kid + k, 1, 1, 1, 1, 1, 1);
    i0 = issued;
    for (int k = 0; k < 3; k++) launch(1, 1, 1, 1, 1, 1);
    chk(issued == i0, "R6", "all refused", issued - i0, 0);
    refuse_all = 0;
    launch(1, 1, 1, 1, 1, 1);
    cyc(4);
    chk(issued - i0 == 4, "R10", "four kernels issued in order", issued - i0, 4);
    launch(9, 9, 9, 1, 1, 1);
    cyc(6);
    chk(issued - i0 == 4, "R10", "launch while full issues nothing", issued - i0, 4);
    rd(0, v); chk(v == 3, "R10", "status active and overflow", v, 3);
    chk(wake_cnt == w0, "R9", "no wake without finished kernel", wake_cnt, w0);
    complete_all();
    for (int k = 0; k < 4; k++) chk_done(next_kid + k, "R8");
    next_kid += 4;
    rd(0, v); chk(v == 2, "R11", "active clear, overflow sticky", v, 2);
    chk(wake_cnt > w0, "R9", "wake after completions", wake_cnt, w0 + 1);

    // next accepted kernel reuses the unconsumed ID (R10)
    exp_kernel(next_kid, 1, 1, 1, 1, 1, 1);
    launch(1, 1, 1, 1, 1, 1);
    cyc(4);
    chk(exp_q.size() == 0, "R10", "id not consumed by ignored launch", exp_q.size(), 0);
    complete_all();
    chk_done(next_kid, "R8");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule